// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the target side of a serial flash read path. It watches an active-low chip select, a serial clock and a serial input line. It answers the fast read command from a small internal byte array, and it drives a serial output line together with an output enable. Each select period starts with a command byte. The block then collects a 24-bit or 32-bit address and waits out eight dummy clocks. After that it streams bytes, most significant bit first, from an address that steps up by one after each byte.

The address wraps to zero past the top of the array, so a single command can read without end. The command is dropped in two cases: when a program or erase is flagged as busy, and when the byte is any other code. In both cases the output stays high impedance until chip select rises. Raising chip select ends everything at once.

The array holds 2^AW bytes. Its contents are a fixed computed pattern, so that a host can check what it reads back.

Top module: `flash_fread_target`

## Requirements
- R1: While chip select is low, the first eight bits sampled on rising serial clock edges form the command, most significant bit first. Only the value 0x0B starts a read.
- R2: The address length is 24 bits when `addr4_mode` is low and 32 bits when it is high. The mode is sampled on the eighth rising edge, and the address is shifted in most significant bit first.
- R3: Eight dummy rising edges follow the address. The first data bit is driven on the falling edge that follows rising edge number 16+L, counting from 1, where L is the address length.
- R4: Data bits are driven on falling serial clock edges, most significant bit of each byte first.
- R5: After each full byte the read index increments by one. After index 2^AW-1 it wraps to 0.
- R6: Chip select going high at any time ends the operation and drops `so_oe` at once. A new command is then accepted on the next select period.
- R7: If `busy` is high on the eighth rising edge, the command is discarded and `so_oe` stays low until chip select rises.
- R8: Any command value other than 0x0B is ignored, and `so_oe` stays low until chip select rises.
- R9: Address bits above the low AW bits are ignored.
- R10: `so_oe` is high only during the data phase. `so` is high impedance whenever `so_oe` is low.
- R11: The byte at index i is the low 8 bits of (29*i + 0x5A) XOR (i >> 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cs_n | input | 1 | Chip select, active low; high also resets the block |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial input: command and address bits |
| addr4_mode | input | 1 | High selects the 32-bit address, low the 24-bit address |
| busy | input | 1 | A program or erase cycle is in progress |
| so | output | 1 | Serial data output, high impedance when not enabled |
| so_oe | output | 1 | Output enable for `so` |

## Verification
The bench builds the block with its default AW of 8, which gives a 256-byte array. With that size a wrap past index 255 takes only a few bytes. Both 24-bit and 32-bit addresses also carry upper bits that the block must drop. The reference model predicts the level of `so_oe` and `so` on every rising edge. It covers reads in both address modes, a read that crosses the wrap, a busy-blocked command, a foreign command, and a select that rises in the middle of a byte and is followed by a fresh read.

// File: rtl/flash_fread_target.sv
module flash_fread_target #(
  parameter int AW = 8,
  parameter logic [7:0] CMD_READ = 8'h0B,
  parameter int DUMMY = 8
) (
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic addr4_mode,
  input  logic busy,
  output logic so,
  output logic so_oe
);
  localparam int CW = 6;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_IGN} phase_t;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [7:0]      cmd_sr;
  logic [31:0]     addr_q;
  logic            mode4_q;
  logic            oe_q, so_q;
  logic [2:0]      bidx;
  logic [AW-1:0]   ptr, cur;
  logic [7:0]      cmd_now;
  logic [CW-1:0]   alen_m1;

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] i);
    logic [31:0] w;
    w = 32'(i);
    return 8'(w * 32'd29 + 32'h5A) ^ 8'(w >> 8);
  endfunction

  assign cmd_now = {cmd_sr[6:0], si};
  assign alen_m1 = mode4_q ? CW'(31) : CW'(23);
  assign cur     = oe_q ? ptr : addr_q[AW-1:0];

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      cmd_sr  <= '0;
      addr_q  <= '0;
      mode4_q <= 1'b0;
    end else begin
      case (phase)
        PH_CMD: begin
          cmd_sr <= cmd_now;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt     <= '0;
            mode4_q <= addr4_mode;
            phase   <= (cmd_now == CMD_READ && !busy) ? PH_ADDR : PH_IGN;
          end
        end
        PH_ADDR: begin
          addr_q <= {addr_q[30:0], si};
          cnt    <= cnt + 1'b1;
          if (cnt == alen_m1) begin
            cnt   <= '0;
            phase <= PH_DUMMY;
          end
        end
        PH_DUMMY: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DUMMY - 1)) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) begin
      oe_q <= 1'b0;
      so_q <= 1'b0;
      bidx <= 3'd7;
      ptr  <= '0;
    end else if (phase == PH_DATA) begin
      oe_q <= 1'b1;
      so_q <= rom_byte(cur)[bidx];
      bidx <= bidx - 3'd1;
      ptr  <= (bidx == 3'd0) ? cur + 1'b1 : cur;
    end
  end

  assign so_oe = oe_q;
  assign so    = oe_q ? so_q : 1'bz;

  AST_IGN_HOLD: assert property (@(posedge sck) disable iff (cs_n)
    phase == PH_IGN |=> phase == PH_IGN); // R8
  AST_BUSY_DROP: assert property (@(posedge sck) disable iff (cs_n)
    (phase == PH_CMD && cnt == CW'(7) && busy) |=> phase == PH_IGN); // R7
  AST_DUMMY_STAY: assert property (@(posedge sck) disable iff (cs_n)
    (phase == PH_DUMMY && cnt != CW'(DUMMY - 1)) |=> phase == PH_DUMMY); // R3
  AST_DUMMY_EXIT: assert property (@(posedge sck) disable iff (cs_n)
    (phase == PH_DUMMY && cnt == CW'(DUMMY - 1)) |=> phase == PH_DATA); // R3
  AST_OE_DATA: assert property (@(negedge sck) disable iff (cs_n)
    oe_q |-> phase == PH_DATA); // R10
  AST_BIT_ORDER: assert property (@(negedge sck) disable iff (cs_n)
    (oe_q && $past(oe_q)) |-> bidx == $past(bidx) - 3'd1); // R4
endmodule

// File: tb/sim_flash_fread_target.sv
`timescale 1ns/1ps
module sim_flash_fread_target;
  localparam int AW = 8;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, addr4_mode = 1'b0, busy = 1'b0;
  wire so, so_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  flash_fread_target #(.AW(AW)) u0 (.cs_n(cs_n), .sck(sck), .si(si),
    .addr4_mode(addr4_mode), .busy(busy), .so(so), .so_oe(so_oe));

  always #4 sck = ~sck;

  function automatic logic [7:0] model_byte(input int i);
    int v;
    v = i % (1 << AW);
    return 8'((v * 29 + 32'h5A) ^ (v >> 8));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic [7:0] cmd, input logic [31:0] a, input bit m4,
                     input bit bz, input int nbits, input string req);
    bit tx[$];
    bit expq[$];
    int alen, hdr, total;
    bit ok;
    alen = m4 ? 32 : 24;
    hdr  = 16 + alen;
    ok   = (cmd == 8'h0B) && !bz;
    for (int i = 7; i >= 0; i--) tx.push_back(cmd[i]);
    for (int i = alen - 1; i >= 0; i--) tx.push_back(a[i]);
    for (int i = 0; i < 8; i++) tx.push_back(1'b0);
    for (int j = 0; j < nbits; j++)
      expq.push_back(model_byte((a % (1 << AW)) + j / 8)[7 - j % 8]);
    total = hdr + nbits;
    @(negedge sck);
    addr4_mode = m4; busy = bz; cs_n = 1'b0;
    for (int k = 0; k < total; k++) begin
      si = (k < tx.size()) ? tx[k] : 1'b0;
      @(posedge sck);
      #1;
      if (ok && k >= hdr) begin
        check(so_oe === 1'b1, {req, " R10 oe in data"}, so_oe, 1);
        check(so === expq[k - hdr], {req, " R4 R5 R11 data bit"}, so, expq[k - hdr]);
      end else begin
        check(so_oe === 1'b0, {req, " R10 oe outside data"}, so_oe, 0);
      end
      @(negedge sck);
    end
    cs_n = 1'b1; busy = 1'b0;
    #1;
    check(so_oe === 1'b0, "R6 oe drops on deselect", so_oe, 0);
    repeat (2) @(negedge sck);
  endtask

  initial begin
    repeat (3) @(negedge sck);
    check(so_oe === 1'b0, "R10 reset state", so_oe, 0);
    run(8'h0B, 32'h0000_0010, 1'b0, 1'b0, 32, "R1 R2 R3 3-byte read");
    run(8'h0B, 32'h1234_5678, 1'b1, 1'b0, 24, "R2 R9 4-byte read");
    run(8'h0B, 32'h00FF_00A0, 1'b0, 1'b0, 16, "R9 upper bits dropped");
    run(8'h0B, 32'h0000_00FC, 1'b0, 1'b0, 64, "R5 wrap read");
    run(8'h0B, 32'h0000_0020, 1'b0, 1'b1, 24, "R7 busy blocks");
    run(8'h03, 32'h0000_0020, 1'b0, 1'b0, 24, "R8 foreign command");
    run(8'h0B, 32'h0000_0040, 1'b1, 1'b0, 13, "R6 mid-byte stop");
    run(8'h0B, 32'h0000_0041, 1'b0, 1'b0, 16, "R6 read after stop");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule